// File: doc/BRIEF.md
# Up/Down Gain Code Stepper

This block holds a 6-bit gain code for one amplifier channel and moves it through pulses on a slow step-clock input. A direction input sets which way each pulse moves the code. A 2-bit select chooses the step size. Code 0 is the highest gain and code 63 is the lowest. Raising the gain therefore lowers the code. The code saturates at both ends of its range and never wraps.

One pulse pattern is not a step. If the direction level seen when the step clock rises differs from the level seen when it falls, the pulse is a reset, and the code goes to all ones (minimum gain). Both orders of the two levels count as a reset. The block runs on a fast system clock and oversamples the step-clock, direction and select inputs through two-flop synchronisers. It acts exactly once per pulse, when it detects the falling edge. The code output drives the attenuator selector.

Top module: `gain_stepper`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it is released, gain_code equals 63 (all ones, minimum gain).
- R2: A pulse whose direction level is 1 at both edges lowers gain_code by the selected step count.
- R3: A pulse whose direction level is 0 at both edges raises gain_code by the selected step count.
- R4: The step select maps 2'b00 to 1 count, 2'b01 to 2 counts, 2'b10 to 4 counts and 2'b11 to 8 counts. Each count is 0.5 dB.
- R5: A gain-raising step that would pass code 0 leaves gain_code at 0.
- R6: A gain-lowering step that would pass code 63 leaves gain_code at 63.
- R7: A pulse with direction 0 at the rising edge and 1 at the falling edge sets gain_code to 63, whatever the select.
- R8: A pulse with direction 1 at the rising edge and 0 at the falling edge sets gain_code to 63.
- R9: gain_code changes only after a falling edge of the step clock, by at most one action per pulse. The action is visible within five system clocks of that edge. A rising edge, or a direction change while the step clock is high, leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the step inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| step_clk_in | input | 1 | Asynchronous step clock; one high pulse is one action |
| step_dir_in | input | 1 | Asynchronous direction level: 1 raises gain, 0 lowers it |
| step_sel | input | 2 | Step size select, in counts of 0.5 dB (see R4) |
| gain_code | output | 6 | Gain code: 0 is maximum gain, 63 is minimum gain |

## Verification
The bench walks the code into both rails with large steps and pushes past them. A design that wraps would jump from 0 to the far end of the range, or from 63 to a low code. It applies each select value against a known start code, so a swapped size mapping shows up as a wrong difference. It drives reset pulses in both level orders from mid-range codes. It also changes the direction level while the step clock is high and checks that the code holds. A design that acted on the rising edge, or treated any direction change as a reset, would move the code too early or to the wrong value. A seeded random run of mixed steps and resets is then checked against a bench model.

// File: rtl/gs_pkg.sv
// Shared types for the gain stepper.
// Assumes: one decoded action per detected step-clock falling edge.
package gs_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_UP    = 2'd1,   // raise gain: code moves toward 0
        ACT_DOWN  = 2'd2,   // lower gain: code moves toward max
        ACT_RESET = 2'd3    // force minimum gain
    } gs_action_e;

endpackage

// File: rtl/gs_sync.sv
// Multi-stage synchroniser for a bus of quasi-static asynchronous levels.
// Assumes: each bit is sampled on its own; bits need not be coherent.
module gs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // shift the asynchronous input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gs_pulse_decode.sv
// Finds step-clock edges in synchronised samples and decodes one action per pulse.
// Assumes: clk_s and dir_s come through synchronisers of equal depth.
module gs_pulse_decode
    import gs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_s,
    input  logic       dir_s,
    output gs_action_e action
);
    logic clk_d;
    logic dir_at_rise;
    logic rise;
    logic fall;

    assign rise = clk_s & ~clk_d;
    assign fall = ~clk_s & clk_d;

    // remember the previous step-clock sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) clk_d <= 1'b0;
        else        clk_d <= clk_s;
    end

    // capture the direction level seen at each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)    dir_at_rise <= 1'b0;
        else if (rise) dir_at_rise <= dir_s;
    end

    // decode the pulse at its falling edge
    always_comb begin
        action = ACT_NONE;
        if (fall) begin
            if (dir_s != dir_at_rise) action = ACT_RESET;
            else if (dir_at_rise)     action = ACT_UP;
            else                      action = ACT_DOWN;
        end
    end
endmodule

// File: rtl/gs_code_reg.sv
// Holds the gain code and applies a decoded action with saturation at both rails.
// Assumes: the code maximum is all ones; select picks a step of 2**sel counts.
module gs_code_reg
    import gs_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gs_action_e        action,
    input  logic [SEL_W-1:0]  sel,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W:0] CODE_MAX = {1'b0, {CODE_W{1'b1}}};

    logic [CODE_W:0] step;
    logic [CODE_W:0] code_w;
    logic [CODE_W:0] headroom;
    logic [CODE_W:0] next_w;

    assign step     = (CODE_W+1)'(1) << sel;
    assign code_w   = {1'b0, code};
    assign headroom = CODE_MAX - code_w;

    // compute the saturated next code for the current action
    always_comb begin
        next_w = code_w;
        case (action)
            ACT_UP:    next_w = (code_w >= step)   ? code_w - step : '0;
            ACT_DOWN:  next_w = (headroom >= step) ? code_w + step : CODE_MAX;
            ACT_RESET: next_w = CODE_MAX;
            default:   next_w = code_w;
        endcase
    end

    // hold the code; reset to minimum gain
    always_ff @(posedge clk) begin
        if (!rst_n) code <= {CODE_W{1'b1}};
        else        code <= next_w[CODE_W-1:0];
    end
endmodule

// File: rtl/gain_stepper.sv
// Up/down gain code stepper: synchronises the step inputs, decodes pulses, updates the code.
// Assumes: step pulses last several system clocks; select is steady around each pulse.
module gain_stepper
    import gs_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_clk_in,
    input  logic              step_dir_in,
    input  logic [SEL_W-1:0]  step_sel,
    output logic [CODE_W-1:0] gain_code
);
    localparam int SYNC_W = SEL_W + 2;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    gs_action_e        action;

    assign raw_bus = {step_sel, step_dir_in, step_clk_in};

    gs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    gs_pulse_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_s  (sync_bus[0]),
        .dir_s  (sync_bus[1]),
        .action (action)
    );

    gs_code_reg #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .action (action),
        .sel    (sync_bus[SYNC_W-1:2]),
        .code   (gain_code)
    );
endmodule

// File: rtl/gain_stepper_chk.sv
// Property checker for the gain stepper, bound to the top module.
// Assumes: action is the decoded per-pulse action inside the top.
module gain_stepper_chk
    import gs_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input gs_action_e        action,
    input logic [CODE_W-1:0] gain_code
);
    AST_RESET_MIN: assert property (@(posedge clk)
        !rst_n |=> gain_code == {CODE_W{1'b1}});                                   // R1

    AST_UP_NOT_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        action == ACT_UP |=> gain_code <= $past(gain_code));                       // R2

    AST_DOWN_NOT_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
        action == ACT_DOWN |=> gain_code >= $past(gain_code));                     // R3

    AST_PATTERN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        action == ACT_RESET |=> gain_code == {CODE_W{1'b1}});                      // R7

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        action == ACT_NONE |=> $stable(gain_code));                                // R9
endmodule

bind gain_stepper gain_stepper_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .action    (action),
    .gain_code (gain_code)
);

// File: tb/gain_stepper_bench.sv
module gain_stepper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_clk_in = 1'b0;
    logic       step_dir_in = 1'b0;
    logic [1:0] step_sel = 2'b00;
    logic [5:0] gain_code;

    int checks = 0;
    int errors = 0;
    int model  = 63;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gain_stepper u_gain_stepper (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_clk_in (step_clk_in),
        .step_dir_in (step_dir_in),
        .step_sel    (step_sel),
        .gain_code   (gain_code)
    );

    function automatic int next_code(int c, bit d_rise, bit d_fall, bit [1:0] sel);
        int s = 1 << sel;
        if (d_rise != d_fall) return 63;
        if (d_rise) return (c - s < 0) ? 0 : c - s;
        return (c + s > 63) ? 63 : c + s;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(bit d_rise, bit d_fall, bit [1:0] sel, string tag);
        @(negedge clk);
        step_sel    = sel;
        step_dir_in = d_rise;
        repeat (3) @(negedge clk);
        step_clk_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 hold after rise", int'(gain_code), model);
        step_dir_in = d_fall;
        repeat (4) @(negedge clk);
        chk("R9 hold on dir change while high", int'(gain_code), model);
        step_clk_in = 1'b0;
        repeat (5) @(negedge clk);
        model = next_code(model, d_rise, d_fall, sel);
        chk(tag, int'(gain_code), model);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        chk("R1 during reset", int'(gain_code), 63);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(gain_code), 63);

        pulse(1'b0, 1'b0, 2'b11, "R6 lower past 63");
        pulse(1'b1, 1'b1, 2'b00, "R4 sel00 R2 up");
        pulse(1'b1, 1'b1, 2'b01, "R4 sel01 R2 up");
        pulse(1'b1, 1'b1, 2'b10, "R4 sel10 R2 up");
        pulse(1'b1, 1'b1, 2'b11, "R4 sel11 R2 up");
        for (int i = 0; i < 7; i++) pulse(1'b1, 1'b1, 2'b11, "R2 up toward 0");
        pulse(1'b1, 1'b1, 2'b11, "R5 raise past 0");
        pulse(1'b1, 1'b1, 2'b00, "R5 raise at 0");
        pulse(1'b0, 1'b0, 2'b00, "R3 sel00 down");
        pulse(1'b0, 1'b0, 2'b01, "R3 sel01 down");
        pulse(1'b0, 1'b0, 2'b10, "R3 sel10 down");
        pulse(1'b0, 1'b0, 2'b11, "R3 sel11 down");
        pulse(1'b0, 1'b1, 2'b00, "R7 low-then-high reset");
        pulse(1'b1, 1'b1, 2'b11, "R2 up");
        pulse(1'b1, 1'b1, 2'b11, "R2 up");
        pulse(1'b1, 1'b0, 2'b10, "R8 high-then-low reset");
        pulse(1'b1, 1'b1, 2'b01, "R2 up after reset");

        for (int i = 0; i < 150; i++) begin
            bit       dr  = 1'($urandom_range(0, 1));
            bit       df  = ($urandom_range(0, 7) == 0) ? ~dr : dr;
            bit [1:0] sel = 2'($urandom_range(0, 3));
            pulse(dr, df, sel, "R2 R3 R7 R8 random");
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        model = 63;
        chk("R1 mid-run reset", int'(gain_code), 63);
        rst_n = 1'b1;
        pulse(1'b1, 1'b1, 2'b10, "R2 up after mid-run reset");

        finish_run();
    end
endmodule